// File: doc/BRIEF.md
# Quad Latched Bidirectional Port Transceiver

This block joins two four-lane ports and moves data between them. The first is a differential port, with a true and a complement leg for each lane. The second is a single-ended tri-state port. Each port has separate input, output and drive-enable signals, so an external pad ring can build the bidirectional pins.

A direction input chooses which port receives and which one drives. An output-enable input switches the active output off. On the differential side, "off" is a separate cut-off state: both legs are low and a per-lane cut-off flag is raised. This lets several drivers share the bus.

A latch-enable input selects between two modes:
- **Transparent:** the enabled output follows its input in the same cycle.
- **Hold:** the output keeps what was captured before.

Both ports are captured into separate storage whichever direction is active. If the direction is flipped while holding, the output shows the value captured from the newly selected input port. The storage is clocked: while latch enable is low, each rising edge samples the inputs, and a combinational bypass provides the transparent path.

The data here are level signals and not transfers, so there is no valid/ready handshake. All pins are plain levels.

Top module: `quad_xcvr`

## Requirements
- R1: With `dir_i`=0 and `oe_i`=1, the single-ended port drives: `se_oe_o` is all ones, `se_o` carries the differential data, and the differential port is in cut-off.
- R2: With `dir_i`=1 and `oe_i`=1, the differential port drives: for every lane `dp_t_o` equals the data, `dp_c_o` equals its inverse, `dp_cut_o` is 0, and `se_oe_o` is all zeros.
- R3: With `oe_i`=0, in either direction, `dp_cut_o` is all ones, `dp_t_o` and `dp_c_o` are all zeros, and `se_oe_o` is all zeros. `se_o` reads zero whenever `se_oe_o` is low.
- R4: With `le_i`=0, the enabled output follows its selected input combinationally, with no clock edge needed.
- R5: With `le_i`=1, the output shows the value sampled at the last rising clock edge on which `le_i` was 0. Input changes while `le_i`=1 have no effect on it.
- R6: Both input ports are captured together whatever the direction. Flipping `dir_i` while `le_i`=1 shows the value stored from the newly selected input port.
- R7: A differential lane whose true and complement legs are equal raises its bit in `dp_bad_o`. In transparent mode that lane outputs its stored value, and the stored value is not overwritten.
- R8: Reset (`rst_n`=0) clears both storage bits of every lane to 0.
- R9: The lanes are independent. Bit i of each data port affects only bit i of the outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock for the storage |
| rst_n | input | 1 | Active-low synchronous reset of the storage |
| dir_i | input | 1 | 0: differential to single-ended; 1: single-ended to differential |
| oe_i | input | 1 | Output enable; low puts both outputs off |
| le_i | input | 1 | Latch enable; low is transparent, high holds |
| dp_t_i | input | LANES | Differential true legs, received |
| dp_c_i | input | LANES | Differential complement legs, received |
| dp_t_o | output | LANES | Differential true legs, driven |
| dp_c_o | output | LANES | Differential complement legs, driven |
| dp_cut_o | output | LANES | Per-lane cut-off flag for the differential output |
| dp_bad_o | output | LANES | Per-lane flag: received legs are equal |
| se_i | input | LANES | Single-ended data, received |
| se_o | output | LANES | Single-ended data, driven |
| se_oe_o | output | LANES | Per-lane drive enable for the single-ended port |

## Verification
The hardest case to reach is a direction flip while holding. Because only one output is ever enabled, the value stored from the idle port can only be seen by switching direction after latching. The stimulus loads different patterns on the two ports in transparent mode, waits for a clock edge, raises latch enable, and then scrambles both inputs. It then toggles direction and checks each port's output against the pattern captured from the other port. A second hard case is the invalid-leg lane, which must keep an older value while its neighbours update. The stimulus first loads a known pattern, then drives equal legs on selected lanes only.

// File: rtl/xcvr_pkg.sv
package xcvr_pkg;
  typedef enum logic {
    DIR_DP2SE = 1'b0,
    DIR_SE2DP = 1'b1
  } dir_e;
endpackage

// File: rtl/xcvr_diff_rx.sv
module xcvr_diff_rx #(
  parameter int W = 4
) (
  input  logic [W-1:0] t_i,
  input  logic [W-1:0] c_i,
  output logic [W-1:0] bit_o,
  output logic [W-1:0] ok_o
);
  // true leg carries the level; legs must disagree to be trusted
  assign bit_o = t_i;
  assign ok_o  = t_i ^ c_i;
endmodule

// File: rtl/xcvr_hold_bit.sv
module xcvr_hold_bit (
  input  logic clk,
  input  logic rst_n,
  input  logic le_i,
  input  logic ok_i,
  input  logic d_i,
  output logic view_o
);
  logic q;
  logic cap;

  assign cap = ~le_i & ok_i;

  always_ff @(posedge clk) begin
    if (!rst_n)   q <= 1'b0;
    else if (cap) q <= d_i;
  end

  // transparent bypass when sampling, stored value otherwise
  assign view_o = cap ? d_i : q;
endmodule

// File: rtl/quad_xcvr.sv
module quad_xcvr
  import xcvr_pkg::*;
#(
  parameter int LANES = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             dir_i,
  input  logic             oe_i,
  input  logic             le_i,
  input  logic [LANES-1:0] dp_t_i,
  input  logic [LANES-1:0] dp_c_i,
  output logic [LANES-1:0] dp_t_o,
  output logic [LANES-1:0] dp_c_o,
  output logic [LANES-1:0] dp_cut_o,
  output logic [LANES-1:0] dp_bad_o,
  input  logic [LANES-1:0] se_i,
  output logic [LANES-1:0] se_o,
  output logic [LANES-1:0] se_oe_o
);
  localparam logic [LANES-1:0] ZEROS = '0;

  dir_e             dir;
  logic             dp_drive;
  logic             se_drive;
  logic [LANES-1:0] rx_bit;
  logic [LANES-1:0] rx_ok;
  logic [LANES-1:0] dp_view;
  logic [LANES-1:0] se_view;

  assign dir      = dir_e'(dir_i);
  assign dp_drive = oe_i & (dir == DIR_SE2DP);
  assign se_drive = oe_i & (dir == DIR_DP2SE);

  xcvr_diff_rx #(.W(LANES)) u_rx (
    .t_i  (dp_t_i),
    .c_i  (dp_c_i),
    .bit_o(rx_bit),
    .ok_o (rx_ok)
  );

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    xcvr_hold_bit u_dp_hold (
      .clk   (clk),
      .rst_n (rst_n),
      .le_i  (le_i),
      .ok_i  (rx_ok[g]),
      .d_i   (rx_bit[g]),
      .view_o(dp_view[g])
    );
    xcvr_hold_bit u_se_hold (
      .clk   (clk),
      .rst_n (rst_n),
      .le_i  (le_i),
      .ok_i  (1'b1),
      .d_i   (se_i[g]),
      .view_o(se_view[g])
    );
  end

  assign dp_t_o   = dp_drive ? se_view  : ZEROS;
  assign dp_c_o   = dp_drive ? ~se_view : ZEROS;
  assign dp_cut_o = {LANES{~dp_drive}};
  assign dp_bad_o = ~rx_ok;
  assign se_o     = se_drive ? dp_view  : ZEROS;
  assign se_oe_o  = {LANES{se_drive}};
endmodule

// File: rtl/xcvr_chk.sv
module xcvr_chk #(
  parameter int LANES = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             dir_i,
  input logic             oe_i,
  input logic             le_i,
  input logic [LANES-1:0] dp_t_i,
  input logic [LANES-1:0] dp_c_i,
  input logic [LANES-1:0] dp_t_o,
  input logic [LANES-1:0] dp_c_o,
  input logic [LANES-1:0] dp_cut_o,
  input logic [LANES-1:0] dp_bad_o,
  input logic [LANES-1:0] se_i,
  input logic [LANES-1:0] se_o,
  input logic [LANES-1:0] se_oe_o
);
  AST_CUT_LEGS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    ((dp_cut_o & (dp_t_o | dp_c_o)) == '0)); // R3
  AST_LEGS_COMPLEMENT: assert property (@(posedge clk) disable iff (!rst_n)
    ((~dp_cut_o & ~(dp_t_o ^ dp_c_o)) == '0)); // R2
  AST_OE_LOW_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !oe_i |-> (se_oe_o == '0) && (&dp_cut_o)); // R3
  AST_ONE_DRIVER: assert property (@(posedge clk) disable iff (!rst_n)
    ((se_oe_o & ~dp_cut_o) == '0)); // R1
  AST_TRANSP_SE2DP: assert property (@(posedge clk) disable iff (!rst_n)
    (!le_i && dir_i && oe_i) |-> (dp_t_o == se_i)); // R4
  AST_HOLD_DP_OUT: assert property (@(posedge clk) disable iff (!rst_n)
    (le_i && dir_i && oe_i && $past(le_i) && $past(dir_i) && $past(oe_i))
      |-> $stable(dp_t_o)); // R5
  AST_HOLD_SE_OUT: assert property (@(posedge clk) disable iff (!rst_n)
    (le_i && !dir_i && oe_i && $past(le_i) && !$past(dir_i) && $past(oe_i))
      |-> $stable(se_o)); // R5
endmodule

bind quad_xcvr xcvr_chk #(.LANES(LANES)) u_chk (.*);

// File: tb/tb_quad_xcvr.sv
module tb_quad_xcvr;
  localparam int N = 4;

  logic         clk = 1'b0;
  logic         rst_n, dir_i, oe_i, le_i;
  logic [N-1:0] dp_t_i, dp_c_i, se_i;
  logic [N-1:0] dp_t_o, dp_c_o, dp_cut_o, dp_bad_o, se_o, se_oe_o;

  int checks = 0;
  int failures = 0;

  always #2.5 clk = ~clk;

  quad_xcvr #(.LANES(N)) dut (.*);

  task automatic chk(input string req, input logic [N-1:0] act, input logic [N-1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s act=%b exp=%b", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
    #1;
  endtask

  task automatic t_reset();
    rst_n = 0; dir_i = 0; oe_i = 1; le_i = 1;
    dp_t_i = 4'b1111; dp_c_i = 4'b0000; se_i = 4'b1111;
    repeat (3) step();
    rst_n = 1;
    step();
    chk("R8 se_o after reset", se_o, 4'b0000);
    dir_i = 1; #1;
    chk("R8 dp_t_o after reset", dp_t_o, 4'b0000);
    chk("R8 dp_c_o after reset", dp_c_o, 4'b1111);
  endtask

  task automatic t_dp_to_se();
    le_i = 0; oe_i = 1; dir_i = 0;
    dp_t_i = 4'b1001; dp_c_i = 4'b0110; #1;
    chk("R1 se_o follows", se_o, 4'b1001);
    chk("R1 se_oe_o", se_oe_o, 4'b1111);
    chk("R1 dp cut-off", dp_cut_o, 4'b1111);
    dp_t_i = 4'b0100; dp_c_i = 4'b1011; #1;
    chk("R4 R9 se_o follows without edge", se_o, 4'b0100);
  endtask

  task automatic t_se_to_dp();
    le_i = 0; oe_i = 1; dir_i = 1; se_i = 4'b1100; #1;
    chk("R2 dp_t_o", dp_t_o, 4'b1100);
    chk("R2 dp_c_o", dp_c_o, 4'b0011);
    chk("R2 cut-off clear", dp_cut_o, 4'b0000);
    chk("R2 se_oe_o off", se_oe_o, 4'b0000);
    se_i = 4'b0010; #1;
    chk("R4 R9 dp_t_o follows", dp_t_o, 4'b0010);
  endtask

  task automatic t_oe_off();
    le_i = 0; se_i = 4'b1111; dp_t_i = 4'b1111; dp_c_i = 4'b0000;
    for (int d = 0; d < 2; d++) begin
      dir_i = d[0]; oe_i = 0; #1;
      chk("R3 cut-off", dp_cut_o, 4'b1111);
      chk("R3 dp_t_o low", dp_t_o, 4'b0000);
      chk("R3 dp_c_o low", dp_c_o, 4'b0000);
      chk("R3 se_oe_o off", se_oe_o, 4'b0000);
      chk("R3 se_o zero", se_o, 4'b0000);
    end
    oe_i = 1;
  endtask

  task automatic t_hold();
    le_i = 0; oe_i = 1; dir_i = 1; se_i = 4'b1010;
    step();
    le_i = 1; se_i = 4'b0101; #1;
    chk("R5 held dp_t_o", dp_t_o, 4'b1010);
    chk("R5 held dp_c_o", dp_c_o, 4'b0101);
    step(); step();
    chk("R5 held across edges", dp_t_o, 4'b1010);
    le_i = 0; #1;
    chk("R4 reopen follows", dp_t_o, 4'b0101);
  endtask

  task automatic t_flip();
    le_i = 0; oe_i = 1; dir_i = 0;
    dp_t_i = 4'b0011; dp_c_i = 4'b1100; se_i = 4'b0110;
    step();
    le_i = 1;
    dp_t_i = 4'b1110; dp_c_i = 4'b0001; se_i = 4'b1001; #1;
    chk("R6 se_o from dp store", se_o, 4'b0011);
    dir_i = 1; #1;
    chk("R6 dp_t_o from se store", dp_t_o, 4'b0110);
    step();
    dir_i = 0; #1;
    chk("R6 se_o after flip back", se_o, 4'b0011);
  endtask

  task automatic t_invalid();
    le_i = 0; oe_i = 1; dir_i = 0;
    dp_t_i = 4'b0101; dp_c_i = 4'b1010;
    step();
    dp_t_i = 4'b1111; dp_c_i = 4'b1001; #1;
    chk("R7 bad flags", dp_bad_o, 4'b1001);
    chk("R7 transparent keeps bad lanes", se_o, 4'b0111);
    step();
    le_i = 1; #1;
    chk("R7 stored bad lanes untouched", se_o, 4'b0111);
    dp_t_i = 4'b0000; dp_c_i = 4'b0000; #1;
    chk("R7 both-low bad", dp_bad_o, 4'b1111);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog act=%0d exp=%0d", 1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    t_reset();
    t_dp_to_se();
    t_se_to_dp();
    t_oe_off();
    t_hold();
    t_flip();
    t_invalid();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule